// File: doc/BRIEF.md
# Two-Channel Interrupt Combiner with Split Routing

This block turns the event strobes of one network interface into interrupt lines. It takes a transmit and a receive DMA event flag for each of two channels, plus an error-detection flag. Every flag latches into a sticky pending bit. Software clears pending bits by writing ones to the status address. A per-bit enable mask decides which pending bits may raise an interrupt.

Two level outputs are driven. By default the main line carries every enabled pending source, and the auxiliary line stays low. When software sets the split bit, events from channel 1 (and any higher channel) move to the auxiliary line. The main line then carries only channel 0 events and the error event. A small register port writes the status, mask and split control, and reads them back combinationally.

Top module: `irq_combiner`

## Requirements
- R1: An event flag that is high at a rising clock edge sets its pending bit after that edge. The bit layout is: bit 2c is the transmit event of channel c, bit 2c+1 is the receive event of channel c, and bit 4 is the error event.
- R2: A pending bit stays set across any number of cycles until software clears it.
- R3: A write to address 0 clears each pending bit whose write-data bit is 1. Pending bits whose write-data bit is 0 keep their value.
- R4: When an event and a clear of the same bit fall on the same edge, the bit ends up set.
- R5: A write to address 1 loads the enable mask. The mask only gates the outputs: pending bits latch whatever the mask holds, and a source with mask 0 never drives an output.
- R6: With split off, irq_main is the OR of all enabled pending bits, and irq_aux is low.
- R7: A write to address 2 loads the split bit from data bit 0. With split on, irq_main is the OR of the enabled pending bits 0, 1 and 4, and irq_aux is the OR of the enabled pending bits 2 and 3.
- R8: An enabled, pending error bit drives irq_main in both split settings.
- R9: Synchronous active-low reset clears all pending bits, the mask and the split bit, and holds both outputs low.
- R10: rd_data returns the pending bits at address 0, the mask at address 1, and the split bit in bit 0 at address 2. Address 3 reads zero, and a write to address 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_evt | input | NUM_CH | Transmit DMA event flag per channel |
| rx_evt | input | NUM_CH | Receive DMA event flag per channel |
| err_evt | input | 1 | Error-detection event flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 2*NUM_CH+1 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 2*NUM_CH+1 | Register read data (combinational) |
| irq_main | output | 1 | Main interrupt level |
| irq_aux | output | 1 | Second interrupt level, active only with split on |

## Verification
The assertions assume that clear strobes reach the pending bits only through a status-address write. They also assume that event flags are sampled strictly at clock edges, so any flag high at an edge counts as one event. The stimulus changes events, write strobes and read addresses only on falling edges, and it holds each event and each write for exactly one rising edge. This keeps the set-versus-clear race defined. The sweep walks every mask, every event pattern and both split settings with the configuration fixed at two channels.

// File: rtl/irq_combiner_pkg.sv
// Package: shared register address encoding for the interrupt combiner.
// Assumes a two-bit register address space.
package irq_combiner_pkg;
    typedef enum logic [1:0] {
        RA_STATUS = 2'd0,
        RA_MASK   = 2'd1,
        RA_CTRL   = 2'd2,
        RA_NONE   = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/irq_status_bank.sv
// Module: sticky pending bits, one per interrupt source.
// Each bit is set by its event flag and cleared by a clear strobe.
// Set has priority over clear. Assumes clr_vec is only non-zero during a
// status-address write.
module irq_status_bank #(
    parameter int NSRC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_vec,
    input  logic [NSRC-1:0] clr_vec,
    output logic [NSRC-1:0] status
);
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        // Purpose: latch one source, with set winning over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          status[i] <= 1'b0;
            else if (set_vec[i]) status[i] <= 1'b1;
            else if (clr_vec[i]) status[i] <= 1'b0;
        end

        a_r1_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> status[i]);
        a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !clr_vec[i]) |=> status[i]);
        a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !set_vec[i]) |=> !status[i]);
        a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && set_vec[i]) |=> status[i]);
    end
endmodule

// File: rtl/irq_cfg_regs.sv
// Module: holds the per-source enable mask and the split control bit.
// Assumes the write strobes are already decoded, at most one at a time.
module irq_cfg_regs #(
    parameter int NSRC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mask_we,
    input  logic            ctrl_we,
    input  logic [NSRC-1:0] wr_data,
    input  logic            split_in,
    output logic [NSRC-1:0] mask,
    output logic            split_en
);
    // Purpose: load the enable mask on a mask-address write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= wr_data;
    end

    // Purpose: load the split bit on a control-address write.
    always_ff @(posedge clk) begin
        if (!rst_n)       split_en <= 1'b0;
        else if (ctrl_we) split_en <= split_in;
    end

    a_r5_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask));
    a_r7_split_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we |=> $stable(split_en));
endmodule

// File: rtl/irq_router.sv
// Module: gates pending bits with the mask and routes them to two lines.
// Sources of channel 1 and above go to the auxiliary line when split is on.
// Channel 0 sources and the error source stay on the main line.
// Purely combinational; assumes the layout tx=2c, rx=2c+1, error=top bit.
module irq_router #(
    parameter int NUM_CH = 2
) (
    input  logic [2*NUM_CH:0] status,
    input  logic [2*NUM_CH:0] mask,
    input  logic              split_en,
    output logic              irq_main,
    output logic              irq_aux
);
    localparam int NSRC    = 2 * NUM_CH + 1;
    localparam int ERR_BIT = 2 * NUM_CH;

    logic [NSRC-1:0] aux_set;
    logic [NSRC-1:0] pend;

    for (genvar i = 0; i < NSRC; i++) begin : g_route
        if (i >= 2 && i < ERR_BIT) begin : g_aux
            assign aux_set[i] = 1'b1;
        end else begin : g_main
            assign aux_set[i] = 1'b0;
        end
    end

    // Purpose: form the enabled pending set and OR it onto each line.
    always_comb begin
        pend     = status & mask;
        irq_aux  = split_en & (|(pend & aux_set));
        irq_main = split_en ? |(pend & ~aux_set) : |pend;
    end
endmodule

// File: rtl/irq_combiner.sv
// Module: top of the interrupt combiner for one network interface.
// Packs the event flags into the source vector and decodes the register port.
// Instantiates the pending bank, the config registers and the router.
// Assumes event flags are synchronous to clk.
module irq_combiner
    import irq_combiner_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   tx_evt,
    input  logic [NUM_CH-1:0]   rx_evt,
    input  logic                err_evt,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [2*NUM_CH:0]   wr_data,
    input  logic [1:0]          rd_addr,
    output logic [2*NUM_CH:0]   rd_data,
    output logic                irq_main,
    output logic                irq_aux
);
    localparam int NSRC    = 2 * NUM_CH + 1;
    localparam int ERR_BIT = 2 * NUM_CH;

    logic [NSRC-1:0] evt_vec;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] status;
    logic [NSRC-1:0] mask;
    logic            split_en;
    logic            mask_we;
    logic            ctrl_we;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_pack
        assign evt_vec[2*c]   = tx_evt[c];
        assign evt_vec[2*c+1] = rx_evt[c];
    end
    assign evt_vec[ERR_BIT] = err_evt;

    // Purpose: decode the write port into clear and load strobes.
    always_comb begin
        clr_vec = (wr_en && wr_addr == RA_STATUS) ? wr_data : '0;
        mask_we = wr_en && (wr_addr == RA_MASK);
        ctrl_we = wr_en && (wr_addr == RA_CTRL);
    end

    // Purpose: select the register seen on the read port.
    always_comb begin
        unique case (reg_addr_e'(rd_addr))
            RA_STATUS: rd_data = status;
            RA_MASK:   rd_data = mask;
            RA_CTRL:   rd_data = {{(NSRC-1){1'b0}}, split_en};
            default:   rd_data = '0;
        endcase
    end

    irq_status_bank #(.NSRC(NSRC)) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (evt_vec),
        .clr_vec (clr_vec),
        .status  (status)
    );

    irq_cfg_regs #(.NSRC(NSRC)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_we  (mask_we),
        .ctrl_we  (ctrl_we),
        .wr_data  (wr_data),
        .split_in (wr_data[0]),
        .mask     (mask),
        .split_en (split_en)
    );

    irq_router #(.NUM_CH(NUM_CH)) i_router (
        .status   (status),
        .mask     (mask),
        .split_en (split_en),
        .irq_main (irq_main),
        .irq_aux  (irq_aux)
    );

    a_r6_aux_off: assert property (@(posedge clk) disable iff (!rst_n)
        !split_en |-> !irq_aux);
    a_r8_err_main: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ERR_BIT] && mask[ERR_BIT]) |-> irq_main);
    a_r5_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> (!irq_main && !irq_aux));
    a_r7_ch0_main: assert property (@(posedge clk) disable iff (!rst_n)
        (split_en && (|(status[1:0] & mask[1:0]))) |-> irq_main);
endmodule

// File: tb/test_irq_combiner.sv
module test_irq_combiner;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] tx_evt, rx_evt;
    logic       err_evt, wr_en;
    logic [1:0] wr_addr, rd_addr;
    logic [4:0] wr_data, rd_data;
    logic       irq_main, irq_aux;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    irq_combiner #(.NUM_CH(2)) i_irq_combiner (
        .clk(clk), .rst_n(rst_n), .tx_evt(tx_evt), .rx_evt(rx_evt),
        .err_evt(err_evt), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_main(irq_main), .irq_aux(irq_aux)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [4:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // One rising edge with the given write and event pattern (bit layout per R1).
    task automatic step(input logic we, input logic [1:0] a,
                        input logic [4:0] d, input logic [4:0] ev);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        tx_evt = {ev[2], ev[0]}; rx_evt = {ev[3], ev[1]}; err_evt = ev[4];
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; tx_evt = '0; rx_evt = '0; err_evt = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        logic [4:0] v;
        rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        tx_evt = 0; rx_evt = 0; err_evt = 0;
        do_reset();

        // R9: reset state
        rd(2'd0, v); chk("R9 status", v, 0);
        rd(2'd1, v); chk("R9 mask", v, 0);
        rd(2'd2, v); chk("R9 split", v, 0);
        chk("R9 main", irq_main, 0); chk("R9 aux", irq_aux, 0);

        // R5 R6 R7 R8 R1: exhaustive sweep over split, mask and event pattern
        for (int s = 0; s < 2; s++) begin
            step(1'b1, 2'd2, 5'(s), '0);
            rd(2'd2, v); chk("R7 split readback", v, s);
            for (int m = 0; m < 32; m++) begin
                step(1'b1, 2'd1, 5'(m), '0);
                for (int p = 0; p < 32; p++) begin
                    logic [4:0] en;
                    step(1'b1, 2'd0, 5'h1f, '0);
                    step(1'b0, 2'd0, '0, 5'(p));
                    en = 5'(p & m);
                    rd(2'd0, v); chk("R1 pending latched", v, p);
                    if (s == 0) begin
                        chk("R6 main", irq_main, int'(|en));
                        chk("R6 aux", irq_aux, 0);
                    end else begin
                        chk("R7 main", irq_main, int'(|(en & 5'b10011)));
                        chk("R7 aux", irq_aux, int'(|(en & 5'b01100)));
                    end
                    if (en[4]) chk("R8 err on main", irq_main, 1);
                end
            end
        end

        // R2: sticky across idle cycles
        step(1'b1, 2'd0, 5'h1f, '0);
        step(1'b1, 2'd1, 5'h1f, '0);
        step(1'b0, 2'd0, '0, 5'b00100);
        repeat (5) @(negedge clk);
        rd(2'd0, v); chk("R2 sticky", v, 5'b00100);

        // R3: partial write-one-to-clear
        step(1'b0, 2'd0, '0, 5'h1f);
        step(1'b1, 2'd0, 5'b00101, '0);
        rd(2'd0, v); chk("R3 partial clear", v, 5'b11010);

        // R4: event and clear on the same edge
        step(1'b1, 2'd0, 5'h1f, 5'b00010);
        rd(2'd0, v); chk("R4 set wins", v, 5'b00010);

        // R10: address 3 reads zero and writes there change nothing
        step(1'b1, 2'd3, 5'h00, '0);
        rd(2'd0, v); chk("R10 status kept", v, 5'b00010);
        rd(2'd1, v); chk("R10 mask kept", v, 5'h1f);
        rd(2'd2, v); chk("R10 split kept", v, 1);
        rd(2'd3, v); chk("R10 addr3 zero", v, 0);

        // R9: mid-run reset
        do_reset();
        rd(2'd0, v); chk("R9 status after reset", v, 0);
        rd(2'd1, v); chk("R9 mask after reset", v, 0);
        rd(2'd2, v); chk("R9 split after reset", v, 0);
        chk("R9 main after reset", irq_main, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule